// File: doc/BRIEF.md
# FIFO Fill-Level Interrupt Generator

This block decides when a serial port with a 64-entry receive queue and a 64-entry transmit queue should interrupt its host, and which cause to report. It watches the receive fill count, the transmit fill count, the receive line-error flags, a receive-timeout pulse and three flow/pin change pulses. It compares the fill counts against thresholds and gates every cause with its own enable. It drives an active-low interrupt line and an identification byte that names the most urgent pending cause.

There are two ways to set each threshold. A coarse two-bit selection is written with a control strobe. A fine four-bit field, in steps of four entries, is written with a second strobe. A nonzero fine field takes precedence over the coarse selection. Pulsed causes (timeout, XOFF seen, CTS/RTS change, pin change) are held in sticky latches. The host clears a latch by strobing an identification-read while that cause is the one reported.

Top module: `irq_trigger_gen`

## Requirements
- R1: After reset `irq_n` is 1 and `irq_id` is 0x01. The coarse selections and fine fields are all zero, so both thresholds are 8 entries.
- R2: The coarse receive selection codes 0, 1, 2 and 3 give thresholds of 8, 16, 56 and 60. Receive data is pending when `rx_level` >= threshold and `ena_rxd` is 1. It reports 0x04.
- R3: The coarse transmit selection codes 0, 1, 2 and 3 give thresholds of 8, 16, 32 and 56 free spaces. Transmit space is pending when 64 - `tx_level` >= threshold and `ena_txe` is 1. It reports 0x02.
- R4: A `fcr_wr` strobe always loads the receive selection. It loads the transmit selection only when `enh_en` is 1; otherwise the old transmit selection is kept.
- R5: A nonzero fine field F sets that direction's threshold to 4*F. A fine field of 0 falls back to the coarse selection.
- R6: Any set bit of `line_err` with `ena_lsr` = 1 is pending and reports 0x06.
- R7: An `rx_tmo` pulse sets a sticky timeout latch. It is pending when `ena_rxd` is 1 and reports 0x0C, which keeps bit 0 clear. It is cleared by `id_read` while 0x0C is reported.
- R8: `xoff_evt` (gated by `ena_xoff`, code 0x10) sets a sticky latch, and so do `flow_evt` (code 0x20) and `gpio_evt` (code 0x30), both gated by `ena_msr`. Each latch is cleared by `id_read` only while its own code is reported.
- R9: When several causes are pending, they are reported in this order: line error, timeout, receive data, transmit space, XOFF, CTS/RTS change, pin change.
- R10: `irq_n` is 0 exactly when some enabled cause is pending. `irq_id` is 0x01 when none is pending, and its bit 0 always equals `irq_n`.
- R11: A level change on an input appears on the outputs after one clock edge. An event pulse appears after two edges. A configuration strobe appears after two edges.
- R12: A latch set while its cause is disabled stays set and is reported once the cause is enabled. `id_read` while a level-based cause is reported clears nothing.
- R13: When an event pulse and the clearing `id_read` for the same latch fall in one cycle, the latch stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fcr_wr | input | 1 | Strobe loading the coarse selections |
| fcr_rx_sel | input | 2 | Coarse receive threshold selection |
| fcr_tx_sel | input | 2 | Coarse transmit threshold selection |
| enh_en | input | 1 | Permits loading of the transmit selection |
| tlr_wr | input | 1 | Strobe loading the fine fields |
| tlr_rx | input | 4 | Fine receive threshold, units of 4 |
| tlr_tx | input | 4 | Fine transmit threshold, units of 4 |
| ena_rxd | input | 1 | Enable for receive data and timeout |
| ena_txe | input | 1 | Enable for transmit space |
| ena_lsr | input | 1 | Enable for line errors |
| ena_msr | input | 1 | Enable for CTS/RTS and pin changes |
| ena_xoff | input | 1 | Enable for XOFF seen |
| rx_level | input | 7 | Receive queue fill count, 0..64 |
| tx_level | input | 7 | Transmit queue fill count, 0..64 |
| line_err | input | 4 | Overrun, parity, framing and break flags |
| rx_tmo | input | 1 | Receive timeout pulse |
| xoff_evt | input | 1 | XOFF character seen pulse |
| flow_evt | input | 1 | CTS/RTS change pulse |
| gpio_evt | input | 1 | Pin change pulse |
| id_read | input | 1 | Host read of the identification byte |
| irq_n | output | 1 | Active-low interrupt request |
| irq_id | output | 8 | Identification code |

## Verification
Two things can land in the same cycle: a sticky event pulse, and the identification read that would clear that same latch. The bench holds the pin-change latch as the reported cause, then raises `gpio_evt` and `id_read` on the same edge, and expects 0x30 to remain. A second case stacks a line error, a timeout, receive data and transmit space in one cycle. It then removes them one by one and expects each lower cause to surface in turn. Between the directed cases, seeded random fill counts, enables and configuration writes are compared against a bench-side model of the thresholds and the priority.

// File: rtl/irqgen_pkg.sv
package irqgen_pkg;

  localparam logic [7:0] ID_NONE = 8'h01;
  localparam logic [7:0] ID_LINE = 8'h06;
  localparam logic [7:0] ID_TMO  = 8'h0C;
  localparam logic [7:0] ID_RXD  = 8'h04;
  localparam logic [7:0] ID_TXE  = 8'h02;
  localparam logic [7:0] ID_XOFF = 8'h10;
  localparam logic [7:0] ID_FLOW = 8'h20;
  localparam logic [7:0] ID_GPIO = 8'h30;

  localparam int EVT_N   = 4;
  localparam int EV_TMO  = 0;
  localparam int EV_XOFF = 1;
  localparam int EV_FLOW = 2;
  localparam int EV_GPIO = 3;

  function automatic int coarse_rx_level(input logic [1:0] sel);
    case (sel)
      2'd0: return 8;
      2'd1: return 16;
      2'd2: return 56;
      default: return 60;
    endcase
  endfunction

  function automatic int coarse_tx_level(input logic [1:0] sel);
    case (sel)
      2'd0: return 8;
      2'd1: return 16;
      2'd2: return 32;
      default: return 56;
    endcase
  endfunction

  function automatic int eff_level(input int fine, input int coarse, input int step);
    if (fine != 0) return fine * step;
    return coarse;
  endfunction

  function automatic logic [7:0] evt_code(input int idx);
    case (idx)
      EV_TMO:  return ID_TMO;
      EV_XOFF: return ID_XOFF;
      EV_FLOW: return ID_FLOW;
      default: return ID_GPIO;
    endcase
  endfunction

endpackage

// File: rtl/irq_trig_cfg.sv
module irq_trig_cfg
  import irqgen_pkg::*;
#(
  parameter int LVL_W     = 7,
  parameter int FINE_W    = 4,
  parameter int FINE_STEP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fcr_wr,
  input  logic [1:0]        fcr_rx_sel,
  input  logic [1:0]        fcr_tx_sel,
  input  logic              enh_en,
  input  logic              tlr_wr,
  input  logic [FINE_W-1:0] tlr_rx,
  input  logic [FINE_W-1:0] tlr_tx,
  output logic [LVL_W-1:0]  rx_thr,
  output logic [LVL_W-1:0]  tx_thr
);

  logic [1:0]        rx_sel_q, tx_sel_q;
  logic [FINE_W-1:0] rx_fine_q, tx_fine_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sel_q  <= '0;
      tx_sel_q  <= '0;
      rx_fine_q <= '0;
      tx_fine_q <= '0;
    end else begin
      if (fcr_wr) begin
        rx_sel_q <= fcr_rx_sel;
        if (enh_en) tx_sel_q <= fcr_tx_sel;
      end
      if (tlr_wr) begin
        rx_fine_q <= tlr_rx;
        tx_fine_q <= tlr_tx;
      end
    end
  end

  assign rx_thr = LVL_W'(eff_level(int'(rx_fine_q), coarse_rx_level(rx_sel_q), FINE_STEP));
  assign tx_thr = LVL_W'(eff_level(int'(tx_fine_q), coarse_tx_level(tx_sel_q), FINE_STEP));

  // R4: transmit selection is locked while enhanced functions are off
  assert_tx_sel_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fcr_wr && !enh_en) |=> $stable(tx_sel_q));

  // R5: no path yields a zero threshold
  assert_thr_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_thr >= LVL_W'(FINE_STEP)) && (tx_thr >= LVL_W'(FINE_STEP)));

endmodule

// File: rtl/irq_level_detect.sv
module irq_level_detect #(
  parameter int DEPTH = 64,
  parameter int LVL_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] rx_thr,
  input  logic [LVL_W-1:0] tx_thr,
  output logic             rx_hit,
  output logic             tx_hit
);

  localparam logic [LVL_W-1:0] DEPTH_L = LVL_W'(DEPTH);

  logic [LVL_W-1:0] tx_free;

  assign tx_free = (tx_level > DEPTH_L) ? '0 : DEPTH_L - tx_level;
  assign rx_hit  = (rx_level >= rx_thr);
  assign tx_hit  = (tx_free >= tx_thr);

  // R2: an empty receive queue never reaches a threshold
  assert_empty_no_rx_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level == '0) |-> !rx_hit);

  // R3: a full transmit queue never offers enough space
  assert_full_no_tx_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level == DEPTH_L) |-> !tx_hit);

endmodule

// File: rtl/irq_event_latch.sv
module irq_event_latch #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] lat
);

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lat[g] <= 1'b0;
      else if (set[g]) lat[g] <= 1'b1;
      else if (clr[g]) lat[g] <= 1'b0;
    end

    // R13: a new event outranks a clear in the same cycle
    assert_set_wins_R13: assert property (@(posedge clk) disable iff (!rst_n)
      set[g] |=> lat[g]);

    // R8: a latch only rises because of an event
    assert_rise_from_evt_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lat[g]) |-> $past(set[g]));
  end

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import irqgen_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       p_line,
  input  logic       p_tmo,
  input  logic       p_rxd,
  input  logic       p_txe,
  input  logic       p_xoff,
  input  logic       p_flow,
  input  logic       p_gpio,
  output logic [7:0] id_q,
  output logic       irq_n
);

  logic [7:0] id_d;
  logic       any_pend;

  assign any_pend = p_line | p_tmo | p_rxd | p_txe | p_xoff | p_flow | p_gpio;

  always_comb begin
    if (p_line)      id_d = ID_LINE;
    else if (p_tmo)  id_d = ID_TMO;
    else if (p_rxd)  id_d = ID_RXD;
    else if (p_txe)  id_d = ID_TXE;
    else if (p_xoff) id_d = ID_XOFF;
    else if (p_flow) id_d = ID_FLOW;
    else if (p_gpio) id_d = ID_GPIO;
    else             id_d = ID_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q  <= ID_NONE;
      irq_n <= 1'b1;
    end else begin
      id_q  <= id_d;
      irq_n <= ~any_pend;
    end
  end

  // R9: a line error is always the reported cause
  assert_line_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    p_line |=> (id_q == ID_LINE));

  // R10: nothing pending releases the line and reports the idle code
  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !any_pend |=> (irq_n && id_q == ID_NONE));

  // R10: identification bit 0 tracks the request line
  assert_bit0_R10: assert property (@(posedge clk) disable iff (!rst_n)
    id_q[0] == irq_n);

endmodule

// File: rtl/irq_trigger_gen.sv
module irq_trigger_gen
  import irqgen_pkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int FINE_W    = 4,
  parameter int FINE_STEP = 4,
  parameter int ERR_W     = 4,
  localparam int LVL_W    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fcr_wr,
  input  logic [1:0]        fcr_rx_sel,
  input  logic [1:0]        fcr_tx_sel,
  input  logic              enh_en,
  input  logic              tlr_wr,
  input  logic [FINE_W-1:0] tlr_rx,
  input  logic [FINE_W-1:0] tlr_tx,
  input  logic              ena_rxd,
  input  logic              ena_txe,
  input  logic              ena_lsr,
  input  logic              ena_msr,
  input  logic              ena_xoff,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic [LVL_W-1:0]  tx_level,
  input  logic [ERR_W-1:0]  line_err,
  input  logic              rx_tmo,
  input  logic              xoff_evt,
  input  logic              flow_evt,
  input  logic              gpio_evt,
  input  logic              id_read,
  output logic              irq_n,
  output logic [7:0]        irq_id
);

  logic [LVL_W-1:0] rx_thr, tx_thr;
  logic             rx_hit, tx_hit;
  logic [EVT_N-1:0] evt_set, evt_clr, evt_lat;
  logic             p_line, p_tmo, p_rxd, p_txe, p_xoff, p_flow, p_gpio;

  irq_trig_cfg #(
    .LVL_W(LVL_W), .FINE_W(FINE_W), .FINE_STEP(FINE_STEP)
  ) i_cfg (
    .clk(clk), .rst_n(rst_n),
    .fcr_wr(fcr_wr), .fcr_rx_sel(fcr_rx_sel), .fcr_tx_sel(fcr_tx_sel),
    .enh_en(enh_en), .tlr_wr(tlr_wr), .tlr_rx(tlr_rx), .tlr_tx(tlr_tx),
    .rx_thr(rx_thr), .tx_thr(tx_thr)
  );

  irq_level_detect #(.DEPTH(DEPTH), .LVL_W(LVL_W)) i_det (
    .clk(clk), .rst_n(rst_n),
    .rx_level(rx_level), .tx_level(tx_level),
    .rx_thr(rx_thr), .tx_thr(tx_thr),
    .rx_hit(rx_hit), .tx_hit(tx_hit)
  );

  assign evt_set[EV_TMO]  = rx_tmo;
  assign evt_set[EV_XOFF] = xoff_evt;
  assign evt_set[EV_FLOW] = flow_evt;
  assign evt_set[EV_GPIO] = gpio_evt;

  // a latch clears only when the host reads its own code
  for (genvar g = 0; g < EVT_N; g++) begin : g_clr
    assign evt_clr[g] = id_read && (irq_id == evt_code(g));
  end

  irq_event_latch #(.N(EVT_N)) i_lat (
    .clk(clk), .rst_n(rst_n),
    .set(evt_set), .clr(evt_clr), .lat(evt_lat)
  );

  assign p_line = ena_lsr  && (|line_err);
  assign p_tmo  = ena_rxd  && evt_lat[EV_TMO];
  assign p_rxd  = ena_rxd  && rx_hit;
  assign p_txe  = ena_txe  && tx_hit;
  assign p_xoff = ena_xoff && evt_lat[EV_XOFF];
  assign p_flow = ena_msr  && evt_lat[EV_FLOW];
  assign p_gpio = ena_msr  && evt_lat[EV_GPIO];

  irq_prio_enc i_enc (
    .clk(clk), .rst_n(rst_n),
    .p_line(p_line), .p_tmo(p_tmo), .p_rxd(p_rxd), .p_txe(p_txe),
    .p_xoff(p_xoff), .p_flow(p_flow), .p_gpio(p_gpio),
    .id_q(irq_id), .irq_n(irq_n)
  );

  // R12: reading a level-based code leaves every latch untouched
  assert_lvl_read_keeps_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (id_read && (irq_id == ID_RXD || irq_id == ID_TXE || irq_id == ID_LINE))
      |=> (evt_lat == $past(evt_lat)) || (|$past(evt_set)));

endmodule

// File: tb/test_irq_trigger_gen.sv
module test_irq_trigger_gen;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fcr_wr = 0, enh_en = 0, tlr_wr = 0;
  logic [1:0] fcr_rx_sel = 0, fcr_tx_sel = 0;
  logic [3:0] tlr_rx = 0, tlr_tx = 0;
  logic       ena_rxd = 0, ena_txe = 0, ena_lsr = 0, ena_msr = 0, ena_xoff = 0;
  logic [6:0] rx_level = 0, tx_level = 64;
  logic [3:0] line_err = 0;
  logic       rx_tmo = 0, xoff_evt = 0, flow_evt = 0, gpio_evt = 0, id_read = 0;
  logic       irq_n;
  logic [7:0] irq_id;

  int total = 0;
  int bad = 0;

  logic [1:0] m_rx_sel = 0, m_tx_sel = 0;
  logic [3:0] m_rx_fine = 0, m_tx_fine = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_trigger_gen i_irq_trigger_gen (
    .clk(clk), .rst_n(rst_n),
    .fcr_wr(fcr_wr), .fcr_rx_sel(fcr_rx_sel), .fcr_tx_sel(fcr_tx_sel),
    .enh_en(enh_en), .tlr_wr(tlr_wr), .tlr_rx(tlr_rx), .tlr_tx(tlr_tx),
    .ena_rxd(ena_rxd), .ena_txe(ena_txe), .ena_lsr(ena_lsr),
    .ena_msr(ena_msr), .ena_xoff(ena_xoff),
    .rx_level(rx_level), .tx_level(tx_level), .line_err(line_err),
    .rx_tmo(rx_tmo), .xoff_evt(xoff_evt), .flow_evt(flow_evt),
    .gpio_evt(gpio_evt), .id_read(id_read),
    .irq_n(irq_n), .irq_id(irq_id)
  );

  function automatic int b_rx_thr();
    if (m_rx_fine != 0) return 4 * int'(m_rx_fine);
    return (m_rx_sel == 0) ? 8 : (m_rx_sel == 1) ? 16 : (m_rx_sel == 2) ? 56 : 60;
  endfunction

  function automatic int b_tx_thr();
    if (m_tx_fine != 0) return 4 * int'(m_tx_fine);
    return (m_tx_sel == 0) ? 8 : (m_tx_sel == 1) ? 16 : (m_tx_sel == 2) ? 32 : 56;
  endfunction

  // level-only expectation, used when no sticky latch is set
  function automatic logic [7:0] b_expect();
    if (ena_lsr && line_err != 0) return 8'h06;
    if (ena_rxd && int'(rx_level) >= b_rx_thr()) return 8'h04;
    if (ena_txe && (64 - int'(tx_level)) >= b_tx_thr()) return 8'h02;
    return 8'h01;
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] exp_id);
    logic exp_irq;
    exp_irq = (exp_id == 8'h01);
    total++;
    if (irq_id !== exp_id || irq_n !== exp_irq) begin
      bad++;
      $display("FAIL %s: id=%02h irq_n=%0b expected id=%02h irq_n=%0b",
               req, irq_id, irq_n, exp_id, exp_irq);
    end
  endtask

  task automatic wr_fcr(input logic [1:0] rs, input logic [1:0] ts, input logic en);
    fcr_wr = 1; fcr_rx_sel = rs; fcr_tx_sel = ts; enh_en = en;
    m_rx_sel = rs;
    if (en) m_tx_sel = ts;
    step(1);
    fcr_wr = 0;
  endtask

  task automatic wr_tlr(input logic [3:0] r, input logic [3:0] t);
    tlr_wr = 1; tlr_rx = r; tlr_tx = t;
    m_rx_fine = r; m_tx_fine = t;
    step(1);
    tlr_wr = 0;
  endtask

  task automatic do_read();
    id_read = 1;
    step(1);
    id_read = 0;
    step(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: id=%02h irq_n=%0b expected completion", irq_id, irq_n);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unsigned seed_val;
    seed_val = $urandom(32'h1F2E3D4C);
    step(3);
    check("R1 reset", 8'h01);
    rst_n = 1;
    step(2);
    check("R1 after release", 8'h01);

    // R1/R2: default receive threshold of 8
    ena_rxd = 1; rx_level = 7; step(2);
    check("R1 rx 7 below default", 8'h01);
    rx_level = 8; step(2);
    check("R1 rx 8 at default", 8'h04);

    // R2: coarse receive code 3 -> 60
    wr_fcr(2'd3, 2'd0, 1'b0); rx_level = 59; step(2);
    check("R2 rx 59 vs 60", 8'h01);
    rx_level = 60; step(2);
    check("R2 rx 60 vs 60", 8'h04);
    ena_rxd = 0; rx_level = 0;

    // R3: coarse transmit code 3 -> 56 spaces
    ena_txe = 1; wr_fcr(2'd0, 2'd3, 1'b1);
    tx_level = 9; step(2);
    check("R3 free 55 vs 56", 8'h01);
    tx_level = 8; step(2);
    check("R3 free 56 vs 56", 8'h02);

    // R4: a write with enhanced off keeps code 3
    wr_fcr(2'd0, 2'd0, 1'b0); tx_level = 9; step(2);
    check("R4 locked tx select", 8'h01);
    wr_fcr(2'd0, 2'd0, 1'b1); step(2);
    check("R4 unlocked tx select", 8'h02);

    // R5: fine receive 5 -> 20, fine transmit 15 -> 60
    wr_tlr(4'd5, 4'd15); ena_rxd = 1; rx_level = 19; tx_level = 5; step(2);
    check("R5 rx 19 vs fine 20, free 59 vs 60", 8'h01);
    rx_level = 20; step(2);
    check("R5 rx 20 vs fine 20", 8'h04);
    wr_tlr(4'd0, 4'd0); rx_level = 16; step(2);
    check("R5 fine 0 falls back to 8", 8'h04);
    ena_rxd = 0; ena_txe = 0; rx_level = 0; tx_level = 64; step(2);

    // R6: line error only when enabled
    line_err = 4'b0100; step(2);
    check("R6 line err disabled", 8'h01);
    ena_lsr = 1; step(2);
    check("R6 line err enabled", 8'h06);
    line_err = 0; ena_lsr = 0; step(2);

    // R7/R11: timeout latch, two-edge latency, cleared by read
    ena_rxd = 1; rx_tmo = 1; step(1); rx_tmo = 0;
    step(1);
    check("R7 R11 timeout reported", 8'h0C);
    step(3);
    check("R7 timeout sticky", 8'h0C);
    do_read();
    check("R7 timeout cleared", 8'h01);

    // R12: xoff latched while disabled, shown on enable
    xoff_evt = 1; step(1); xoff_evt = 0; step(2);
    check("R12 xoff disabled", 8'h01);
    ena_xoff = 1; step(2);
    check("R12 xoff after enable", 8'h10);

    // R8/R9: xoff over flow over gpio, each read clears its own
    ena_msr = 1; flow_evt = 1; gpio_evt = 1; step(1);
    flow_evt = 0; gpio_evt = 0; step(2);
    check("R9 xoff over flow", 8'h10);
    do_read();
    check("R8 flow after xoff read", 8'h20);
    do_read();
    check("R8 gpio after flow read", 8'h30);

    // R13: event and clearing read in the same cycle
    gpio_evt = 1; id_read = 1; step(1);
    gpio_evt = 0; id_read = 0; step(2);
    check("R13 set wins over read", 8'h30);
    do_read();
    check("R8 gpio cleared", 8'h01);

    // R9: stack line, timeout, rx, tx then peel them off
    ena_lsr = 1; ena_txe = 1; line_err = 4'b0001; rx_level = 8; tx_level = 0;
    rx_tmo = 1; step(1); rx_tmo = 0; step(2);
    check("R9 line first", 8'h06);
    line_err = 0; step(2);
    check("R9 timeout over rx", 8'h0C);
    do_read();
    check("R9 rx over tx", 8'h04);
    do_read();
    check("R12 read of rx code clears nothing", 8'h04);
    rx_level = 0; step(2);
    check("R9 tx shows", 8'h02);
    tx_level = 64; step(2);
    check("R10 idle again", 8'h01);

    // R10/R2/R3/R5: seeded random level traffic
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 3) == 0)
        wr_fcr(2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));
      if ($urandom_range(0, 3) == 0)
        wr_tlr(($urandom_range(0, 1) == 0) ? 4'd0 : 4'($urandom_range(1, 15)),
               ($urandom_range(0, 1) == 0) ? 4'd0 : 4'($urandom_range(1, 15)));
      rx_level = 7'($urandom_range(0, 64));
      tx_level = 7'($urandom_range(0, 64));
      line_err = ($urandom_range(0, 5) == 0) ? 4'($urandom_range(1, 15)) : 4'd0;
      ena_rxd = 1'($urandom_range(0, 1));
      ena_txe = 1'($urandom_range(0, 1));
      ena_lsr = 1'($urandom_range(0, 1));
      step(2);
      check("R10 random levels", b_expect());
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule